// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog timer peripheral that sits behind a simple register bus. The bus carries 16-bit reads and writes within a 32-byte address window. A prescaler divides the system clock down to a slow tick, and each tick decrements a 10-bit down-counter. Software chooses the value the counter restarts from and can halt or run the counter. To keep the timer from expiring, software services it by writing to the count register.

When the count is exhausted, the counter restarts from the stored value and a first-timeout status flag is set. If the count runs out again while that flag is still set, the block records a second-timeout flag and requests a system reset with a one-cycle pulse. A no-reboot control bit suppresses that pulse, and it comes out of reset set. The actual reset generation, the interrupt routing and the bus bridging are handled by neighbouring logic.

Top module: `wdt_timer`

## Requirements
- R1: After reset the count reads 4, offset 0x12 reads 0x0004, offset 0x08 reads 0x0800, offset 0x0C reads 0x0020, offsets 0x04 and 0x06 read 0, and resetReq is 0.
- R2: A read of offset 0x00 returns the count in bits 9:0. While running, the count decreases by one every TICK_DIV clock cycles, with the first decrement TICK_DIV edges after the edge that clears the halt bit.
- R3: Bit 11 of offset 0x08 is the halt bit. While it is 1 the count holds its value. All 16 bits of offset 0x08 read back as written.
- R4: A write of any value to offset 0x00 loads the count from the stored initial value and restarts the tick phase, so the next decrement follows TICK_DIV edges later.
- R5: A write to offset 0x12 updates only bits 9:0 of the initial value. Bits 15:10 keep their content, which is 0.
- R6: A write to offset 0x12 whose bits 9:0 are below 4 leaves the stored initial value unchanged.
- R7: A tick that arrives while the count is 0 reloads the count from the initial value and sets bit 3 of offset 0x04. Writing 1 to that bit clears it, and writing 0 to it has no effect.
- R8: An expiry that occurs while bit 3 of offset 0x04 is set also sets bit 1 of offset 0x06. Writing 1s to bits 1:0 of offset 0x06 clears that bit.
- R9: On such a second expiry, resetReq goes high for exactly one cycle unless bit 5 of offset 0x0C (no-reboot) is 1. Offset 0x0C reads back exactly as written.
- R10: Reads of any other offset return 0, and writes to any other offset change no register.
- R11: busRdData is 0 whenever busRdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read enable, which qualifies busRdData |
| busAddr | input | 5 | Byte offset inside the register window |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, combinational from busAddr |
| resetReq | output | 1 | One-cycle reset request pulse |

## Verification
The bench builds the block with TICK_DIV set to 4 and the other parameters left at their defaults. With that divider, a full first and second expiry with an initial value of 4 takes 40 clock cycles. The bench can therefore compare the count, both status flags and resetReq against a tick model on every cycle of the run, in both no-reboot settings. The short tick also lets the bench check the tick phase restart on reload and the servicing pattern that prevents any timeout within a few hundred cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic reload;     // reload count from initial value, restart tick phase
    logic halt;       // counter frozen
    logic noReboot;   // suppress reset request
    logic clrFirst;   // clear first-timeout flag
    logic clrSecond;  // clear second-timeout flag
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int INIT_MIN = 4,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [CNT_W-1:0]  count,
  input  logic              firstTo,
  input  logic              secondTo,
  output wdtStrobe_t        strobe,
  output logic [CNT_W-1:0]  initVal,
  output logic [DATA_W-1:0] busRdData
);
  localparam logic [ADDR_W-1:0] OFS_COUNT = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] OFS_STS1  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] OFS_STS2  = ADDR_W'(5'h06);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] OFS_AUX   = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] OFS_INIT  = ADDR_W'(5'h12);
  localparam int HALT_BIT     = 11;
  localparam int NOREBOOT_BIT = 5;
  localparam int FIRST_BIT    = 3;
  localparam int SECOND_BIT   = 1;
  localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(1) << HALT_BIT;
  localparam logic [DATA_W-1:0] AUX_RST  = DATA_W'(1) << NOREBOOT_BIT;

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] auxReg;
  logic wrCount, wrSts1, wrSts2, wrCtrl, wrAux, wrInit;
  logic [CNT_W-1:0] newInit;

  assign wrCount = busWrEn && (busAddr == OFS_COUNT);
  assign wrSts1  = busWrEn && (busAddr == OFS_STS1);
  assign wrSts2  = busWrEn && (busAddr == OFS_STS2);
  assign wrCtrl  = busWrEn && (busAddr == OFS_CTRL);
  assign wrAux   = busWrEn && (busAddr == OFS_AUX);
  assign wrInit  = busWrEn && (busAddr == OFS_INIT);
  assign newInit = busWrData[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RST;
      auxReg  <= AUX_RST;
      initVal <= CNT_W'(INIT_MIN);
    end else begin
      if (wrCtrl) ctrlReg <= busWrData;
      if (wrAux)  auxReg  <= busWrData;
      if (wrInit && (newInit >= CNT_W'(INIT_MIN))) initVal <= newInit;
    end
  end

  always_comb begin
    strobe.reload    = wrCount;
    strobe.halt      = ctrlReg[HALT_BIT];
    strobe.noReboot  = auxReg[NOREBOOT_BIT];
    strobe.clrFirst  = wrSts1 && busWrData[FIRST_BIT];
    strobe.clrSecond = wrSts2 && busWrData[SECOND_BIT];
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      case (busAddr)
        OFS_COUNT: busRdData = DATA_W'(count);
        OFS_STS1:  busRdData[FIRST_BIT]  = firstTo;
        OFS_STS2:  busRdData[SECOND_BIT] = secondTo;
        OFS_CTRL:  busRdData = ctrlReg;
        OFS_AUX:   busRdData = auxReg;
        OFS_INIT:  busRdData = DATA_W'(initVal);
        default:   busRdData = '0;
      endcase
    end
  end

  // R6: stored initial value never drops below the floor
  assert_init_floor_R6: assert property (@(posedge clk) disable iff (!rstN)
    initVal >= CNT_W'(INIT_MIN));
  // R3: control register changes only through a bus write
  assert_ctrl_write_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtrl |=> $stable(ctrlReg));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int TICK_DIV = 75_000_000,
  parameter int CNT_W    = 10,
  parameter int INIT_MIN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strobe,
  input  logic [CNT_W-1:0] initVal,
  output logic [CNT_W-1:0] count,
  output logic             firstTo,
  output logic             secondTo,
  output logic             resetReq
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic run, tick, expire;

  assign run    = !strobe.halt;
  assign tick   = run && (preCnt == PRE_LAST) && !strobe.reload;
  assign expire = tick && (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!run || strobe.reload || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= CNT_W'(INIT_MIN);
      firstTo  <= 1'b0;
      secondTo <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= expire && firstTo && !strobe.noReboot;
      if (strobe.reload || expire) count <= initVal;
      else if (tick)               count <= count - CNT_W'(1);
      if (expire)                  firstTo <= 1'b1;
      else if (strobe.clrFirst)    firstTo <= 1'b0;
      if (expire && firstTo)       secondTo <= 1'b1;
      else if (strobe.clrSecond)   secondTo <= 1'b0;
    end
  end

  // R3: a halted counter without reload holds its value
  assert_halt_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.halt && !strobe.reload) |=> $stable(count));
  // R7: first-timeout flag only rises after the count sat at zero
  assert_first_after_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(firstTo) |-> $past(count) == '0);
  // R8: second-timeout flag only rises while first was already set
  assert_second_needs_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secondTo) |-> $past(firstTo));
  // R9: reset request is a single-cycle pulse
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  // R9: no reset request while no-reboot was set
  assert_noreboot_gates_R9: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !$past(strobe.noReboot));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int TICK_DIV = 75_000_000,
  parameter int CNT_W    = 10,
  parameter int INIT_MIN = 4,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              resetReq
);
  wdtStrobe_t       strobe;
  logic [CNT_W-1:0] initVal;
  logic [CNT_W-1:0] count;
  logic             firstTo;
  logic             secondTo;

  wdt_regs #(.CNT_W(CNT_W), .INIT_MIN(INIT_MIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .count(count), .firstTo(firstTo), .secondTo(secondTo),
    .strobe(strobe), .initVal(initVal), .busRdData(busRdData)
  );

  wdt_core #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W), .INIT_MIN(INIT_MIN)) core_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .initVal(initVal), .count(count),
    .firstTo(firstTo), .secondTo(secondTo), .resetReq(resetReq)
  );
endmodule

// File: tb/wdt_timer_tb_top.sv
module wdt_timer_tb_top;
  localparam int DIV = 4;
  localparam logic [4:0] A_CNT = 5'h00, A_S1 = 5'h04, A_S2 = 5'h06, A_CTL = 5'h08,
                         A_AUX = 5'h0C, A_INI = 5'h12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic busRdEn = 1'b0;
  logic [4:0] busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic resetReq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_timer #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .resetReq(resetReq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1;
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic startRun(logic [15:0] init);
    wr(A_CTL, 16'h0800);
    wr(A_S1, 16'h0008);
    wr(A_S2, 16'h0003);
    wr(A_INI, init);
    wr(A_CNT, 16'h0000);
    wr(A_CTL, 16'h0000);
  endtask

  task automatic test_reset_R1();
    logic [15:0] v;
    rd(A_CNT, v); chk("R1 count", v, 16'h0004);
    rd(A_INI, v); chk("R1 init", v, 16'h0004);
    rd(A_CTL, v); chk("R1 ctrl", v, 16'h0800);
    rd(A_AUX, v); chk("R1 aux", v, 16'h0020);
    rd(A_S1, v);  chk("R1 sts1", v, 16'h0000);
    rd(A_S2, v);  chk("R1 sts2", v, 16'h0000);
    chk("R1 resetReq", 16'(resetReq), 16'h0000);
  endtask

  task automatic test_halted_R3();
    logic [15:0] v;
    repeat (20) @(negedge clk);
    rd(A_CNT, v); chk("R3 halted after reset", v, 16'h0004);
    wr(A_CTL, 16'h5A5A);
    rd(A_CTL, v); chk("R3 ctrl readback", v, 16'h5A5A);
    repeat (20) @(negedge clk);
    rd(A_CNT, v); chk("R3 still halted", v, 16'h0004);
  endtask

  task automatic test_init_R5_R6();
    logic [15:0] v;
    wr(A_INI, 16'hFC0A);
    rd(A_INI, v); chk("R5 upper bits kept", v, 16'h000A);
    wr(A_INI, 16'h0002);
    rd(A_INI, v); chk("R6 value 2 ignored", v, 16'h000A);
    wr(A_INI, 16'h0003);
    rd(A_INI, v); chk("R6 value 3 ignored", v, 16'h000A);
    wr(A_INI, 16'h0004);
    rd(A_INI, v); chk("R6 value 4 accepted", v, 16'h0004);
    wr(A_INI, 16'h03FF);
    rd(A_INI, v); chk("R5 max value", v, 16'h03FF);
    wr(A_CNT, 16'hBEEF);
    rd(A_CNT, v); chk("R4 reload to init", v, 16'h03FF);
  endtask

  task automatic test_expiry_R2_R7_R8_R9(bit nr);
    logic [15:0] v;
    int t, pulses;
    wr(A_AUX, nr ? 16'h0020 : 16'h0000);
    rd(A_AUX, v); chk("R9 aux readback", v, nr ? 16'h0020 : 16'h0000);
    startRun(16'h0004);
    pulses = 0;
    for (int k = 1; k <= 10 * DIV + 2; k++) begin
      @(negedge clk);
      t = k / DIV;
      rd(A_CNT, v); chk("R2 count per tick", v, 16'(4 - (t % 5)));
      rd(A_S1, v);  chk("R7 first flag", v, (t >= 5) ? 16'h0008 : 16'h0000);
      rd(A_S2, v);  chk("R8 second flag", v, (t >= 10) ? 16'h0002 : 16'h0000);
      chk("R9 resetReq", 16'(resetReq), (!nr && k == 10 * DIV) ? 16'h0001 : 16'h0000);
      if (resetReq) pulses++;
    end
    chk("R9 pulse count", 16'(pulses), nr ? 16'h0000 : 16'h0001);
    wr(A_CTL, 16'h0800);
    wr(A_S1, 16'h0000);
    rd(A_S1, v); chk("R7 write 0 keeps flag", v, 16'h0008);
    wr(A_S1, 16'h0008);
    rd(A_S1, v); chk("R7 W1C", v, 16'h0000);
    wr(A_S2, 16'h0003);
    rd(A_S2, v); chk("R8 W1C", v, 16'h0000);
  endtask

  task automatic test_reload_R4();
    logic [15:0] v;
    startRun(16'h0004);
    for (int i = 0; i < 6; i++) begin
      repeat (3 * DIV) @(negedge clk);
      wr(A_CNT, 16'h1234);
    end
    rd(A_CNT, v); chk("R4 count after reload", v, 16'h0004);
    repeat (DIV - 1) @(negedge clk);
    rd(A_CNT, v); chk("R4 phase restart hold", v, 16'h0004);
    @(negedge clk);
    rd(A_CNT, v); chk("R4 phase restart tick", v, 16'h0003);
    rd(A_S1, v); chk("R4 serviced no timeout", v, 16'h0000);
  endtask

  task automatic test_halt_mid_R3();
    logic [15:0] c1, c2;
    startRun(16'h0004);
    repeat (2 * DIV + 1) @(negedge clk);
    wr(A_CTL, 16'h0800);
    rd(A_CNT, c1);
    chk("R3 counted before halt", 16'(c1 < 16'h0004), 16'h0001);
    repeat (25) @(negedge clk);
    rd(A_CNT, c2); chk("R3 frozen mid count", c2, c1);
  endtask

  task automatic test_undef_R10_R11();
    logic [15:0] v;
    wr(A_CTL, 16'h0800);
    wr(A_AUX, 16'h0020);
    wr(A_INI, 16'h0007);
    wr(5'h0A, 16'hFFFF);
    wr(5'h13, 16'hFFFF);
    wr(5'h1E, 16'h0001);
    rd(5'h0A, v); chk("R10 read 0x0A", v, 16'h0000);
    rd(5'h02, v); chk("R10 read 0x02", v, 16'h0000);
    rd(5'h13, v); chk("R10 read 0x13", v, 16'h0000);
    rd(A_CTL, v); chk("R10 ctrl untouched", v, 16'h0800);
    rd(A_AUX, v); chk("R10 aux untouched", v, 16'h0020);
    rd(A_INI, v); chk("R10 init untouched", v, 16'h0007);
    busAddr = A_CTL; busRdEn = 1'b0; #1;
    chk("R11 no read enable", busRdData, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset_R1();
    test_halted_R3();
    test_init_R5_R6();
    test_expiry_R2_R7_R8_R9(1'b1);
    test_expiry_R2_R7_R8_R9(1'b0);
    test_reload_R4();
    test_halt_mid_R3();
    test_undef_R10_R11();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule